// File: doc/BRIEF.md
# Segment Table Address Translator

This block relocates and protects memory references made in segmented form. A requester presents a segment number and an offset within that segment. A small table held in registers gives, for each implemented segment, a starting physical address (base) and a segment length (limit). The offset must lie below the limit. If it does, the block returns base plus offset. If it does not, the block returns a protection fault in place of an address, and a trap handler elsewhere deals with it.

Requests enter on a valid/ready stream. Each accepted request yields exactly one response on a second valid/ready stream, one clock after it is accepted. The response stage is a single register. A new request can be taken whenever that register is empty or is being drained in the same cycle: req_ready equals (not rsp_valid) or rsp_ready. While rsp_valid is high and rsp_ready is low, the response is held unchanged and no request is taken.

The table is loaded through a plain configuration port. A write takes effect only when it carries the privilege flag. Every table entry comes out of reset with a limit of zero, so each segment faults until the operating system configures it.

Top module: `seg_xlate`

## Requirements
- R1: After reset, rsp_valid is low, req_ready is high, and every implemented entry has limit 0, so any request to it returns rsp_fault=1.
- R2: A configuration write updates entry cfg_idx with cfg_base and cfg_limit only when cfg_we and cfg_priv are both high. A write with cfg_priv low leaves the entry as it was.
- R3: When the offset is strictly below the entry's limit and no overflow occurs, the response has rsp_fault=0 and rsp_phys equal to base plus offset. For example, base 9300, limit 400 and offset 123 give 9423.
- R4: An offset greater than or equal to the entry's limit returns rsp_fault=1 with rsp_phys=0.
- R5: A segment number at or above NUM_SEG returns rsp_fault=1 with rsp_phys=0.
- R6: When base plus offset does not fit in PA_W bits, the response is rsp_fault=1 with rsp_phys=0. The address never wraps.
- R7: A request accepted at a clock edge (req_valid and req_ready both high) produces rsp_valid high after that same edge. Without an acceptance or a held response, rsp_valid is low.
- R8: req_ready equals (not rsp_valid) or rsp_ready. While rsp_valid is high and rsp_ready is low, rsp_valid, rsp_fault and rsp_phys stay stable.
- R9: A request accepted in the same cycle as a configuration write to its own entry is translated with the entry's contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Table write strobe |
| cfg_priv | input | 1 | Privilege flag; a write is honoured only when this is high |
| cfg_idx | input | SEG_W | Entry to write |
| cfg_base | input | PA_W | New base (physical start address) |
| cfg_limit | input | OFF_W+1 | New limit (segment length) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_seg | input | SEG_W | Segment number of the request |
| req_off | input | OFF_W | Offset within the segment |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_fault | output | 1 | Protection fault (no address) |
| rsp_phys | output | PA_W | Physical address; 0 when faulting |

## Verification
Two results have a fixed timing. req_ready is combinational and is due in the same cycle. A response is due one edge after its request is accepted, and a table write is visible to requests accepted from the following cycle onward. The bench keeps its own model, which updates on the same edge as the design. It changes inputs only at the falling edge and compares every output at that falling edge. Each comparison therefore sees the result that the rising edge just produced, and no check waits on a variable delay. Stalls imposed by back-pressure are handled by this same per-cycle model rather than by fixed waits.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_SEG   = 2'd1,
    FLT_LIMIT = 2'd2,
    FLT_WRAP  = 2'd3
  } flt_cause_e;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int NUM_SEG = 4,
  parameter int SEG_W   = 3,
  parameter int LIM_W   = 13,
  parameter int PA_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_idx,
  input  logic [PA_W-1:0]  wr_base,
  input  logic [LIM_W-1:0] wr_lim,
  input  logic [SEG_W-1:0] rd_idx,
  output logic             rd_hit,
  output logic [PA_W-1:0]  rd_base,
  output logic [LIM_W-1:0] rd_lim
);
  logic [NUM_SEG-1:0][PA_W-1:0]  base_all;
  logic [NUM_SEG-1:0][LIM_W-1:0] lim_all;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
    logic [PA_W-1:0]  base_q;
    logic [LIM_W-1:0] lim_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q <= '0;
        lim_q  <= '0;
      end else if (wr_en && (wr_idx == SEG_W'(g))) begin
        base_q <= wr_base;
        lim_q  <= wr_lim;
      end
    end
    assign base_all[g] = base_q;
    assign lim_all[g]  = lim_q;
  end

  always_comb begin
    rd_hit  = 1'b0;
    rd_base = '0;
    rd_lim  = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (rd_idx == SEG_W'(i)) begin
        rd_hit  = 1'b1;
        rd_base = base_all[i];
        rd_lim  = lim_all[i];
      end
    end
  end
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int OFF_W = 12,
  parameter int LIM_W = 13,
  parameter int PA_W  = 16
) (
  input  logic             hit,
  input  logic [PA_W-1:0]  base,
  input  logic [LIM_W-1:0] lim,
  input  logic [OFF_W-1:0] off,
  output logic [PA_W-1:0]  phys,
  output flt_cause_e       cause
);
  logic [PA_W:0] sum;

  always_comb begin
    sum = {1'b0, base} + (PA_W+1)'(off);
    if (!hit)
      cause = FLT_SEG;
    else if (LIM_W'(off) >= lim)
      cause = FLT_LIMIT;
    else if (sum[PA_W])
      cause = FLT_WRAP;
    else
      cause = FLT_NONE;
    phys = (cause == FLT_NONE) ? sum[PA_W-1:0] : '0;
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 4,
  parameter int SEG_W   = 3,
  parameter int OFF_W   = 12,
  parameter int PA_W    = 16,
  localparam int LIM_W  = OFF_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_priv,
  input  logic [SEG_W-1:0] cfg_idx,
  input  logic [PA_W-1:0]  cfg_base,
  input  logic [LIM_W-1:0] cfg_limit,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [OFF_W-1:0] req_off,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_phys
);
  logic             tbl_hit;
  logic [PA_W-1:0]  tbl_base;
  logic [LIM_W-1:0] tbl_lim;
  logic [PA_W-1:0]  chk_phys;
  flt_cause_e       chk_cause;
  logic             accept;

  seg_table #(
    .NUM_SEG(NUM_SEG), .SEG_W(SEG_W), .LIM_W(LIM_W), .PA_W(PA_W)
  ) u_table (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (cfg_we && cfg_priv),
    .wr_idx (cfg_idx),
    .wr_base(cfg_base),
    .wr_lim (cfg_limit),
    .rd_idx (req_seg),
    .rd_hit (tbl_hit),
    .rd_base(tbl_base),
    .rd_lim (tbl_lim)
  );

  seg_check #(
    .OFF_W(OFF_W), .LIM_W(LIM_W), .PA_W(PA_W)
  ) u_check (
    .hit  (tbl_hit),
    .base (tbl_base),
    .lim  (tbl_lim),
    .off  (req_off),
    .phys (chk_phys),
    .cause(chk_cause)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_phys  <= '0;
    end else if (req_ready) begin
      rsp_valid <= accept;
      if (accept) begin
        rsp_fault <= (chk_cause != FLT_NONE);
        rsp_phys  <= chk_phys;
      end
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int NUM_SEG = 4,
  parameter int SEG_W   = 3,
  parameter int PA_W    = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [SEG_W-1:0] req_seg,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_fault,
  input logic [PA_W-1:0]  rsp_phys
);
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rsp_valid);

  p_fault_no_addr_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_phys == '0));

  p_bad_seg_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && (32'(req_seg) >= NUM_SEG)) |=> (rsp_valid && rsp_fault));

  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);

  p_empty_r7: assert property (@(posedge clk) disable iff (rst)
    (!(req_valid && req_ready) && (!rsp_valid || rsp_ready)) |=> !rsp_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_fault) && $stable(rsp_phys)));

  p_no_take_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind seg_xlate seg_xlate_chk #(
  .NUM_SEG(NUM_SEG), .SEG_W(SEG_W), .PA_W(PA_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_seg(req_seg), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_fault(rsp_fault), .rsp_phys(rsp_phys)
);

// File: tb/seg_xlate_bench.sv
`timescale 1ns/1ps
module seg_xlate_bench;
  localparam int NUM_SEG = 4;
  localparam int SEG_W   = 3;
  localparam int OFF_W   = 12;
  localparam int PA_W    = 16;
  localparam int LIM_W   = OFF_W + 1;
  localparam int PA_MAX  = (1 << PA_W) - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst = 1'b1;
  logic             cfg_we = 1'b0, cfg_priv = 1'b0;
  logic [SEG_W-1:0] cfg_idx = '0;
  logic [PA_W-1:0]  cfg_base = '0;
  logic [LIM_W-1:0] cfg_limit = '0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [SEG_W-1:0] req_seg = '0;
  logic [OFF_W-1:0] req_off = '0;
  logic             rsp_valid;
  logic             rsp_ready = 1'b1;
  logic             rsp_fault;
  logic [PA_W-1:0]  rsp_phys;

  seg_xlate #(.NUM_SEG(NUM_SEG), .SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_seg_xlate (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_idx(cfg_idx),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit), .req_valid(req_valid),
    .req_ready(req_ready), .req_seg(req_seg), .req_off(req_off),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_phys(rsp_phys)
  );

  // Behavioural reference model
  int    base_m [NUM_SEG];
  int    lim_m  [NUM_SEG];
  bit    exp_v = 1'b0;
  bit    exp_f = 1'b0;
  int    exp_p = 0;
  int    checks = 0;
  int    errors = 0;
  string cur = "R1";
  logic  m_ready;
  assign m_ready = !exp_v || rsp_ready;

  always @(posedge clk) begin
    int s, o;
    bit f;
    int p;
    if (rst) begin
      exp_v <= 1'b0;
      for (int i = 0; i < NUM_SEG; i++) begin
        base_m[i] <= 0;
        lim_m[i]  <= 0;
      end
    end else begin
      if (m_ready) begin
        exp_v <= req_valid;
        if (req_valid) begin
          s = int'(req_seg);
          o = int'(req_off);
          f = 1'b1;
          p = 0;
          if (s < NUM_SEG) begin
            if (o < lim_m[s] && base_m[s] + o <= PA_MAX) begin
              f = 1'b0;
              p = base_m[s] + o;
            end
          end
          exp_f <= f;
          exp_p <= p;
        end
      end
      if (cfg_we && cfg_priv && int'(cfg_idx) < NUM_SEG) begin
        base_m[cfg_idx] <= int'(cfg_base);
        lim_m[cfg_idx]  <= int'(cfg_limit);
      end
    end
  end

  task automatic compare();
    checks++;
    if (rsp_valid !== exp_v || req_ready !== m_ready ||
        (exp_v && (rsp_fault !== exp_f || int'(rsp_phys) !== exp_p))) begin
      errors++;
      $display("FAIL %s: valid/ready/fault/phys actual %0b/%0b/%0b/%0d expected %0b/%0b/%0b/%0d",
               cur, rsp_valid, req_ready, rsp_fault, rsp_phys, exp_v, m_ready, exp_f, exp_p);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic send(input int s, input int o);
    bit acc;
    req_valid = 1'b1;
    req_seg   = SEG_W'(s);
    req_off   = OFF_W'(o);
    do begin
      acc = m_ready;
      tick();
    end while (!acc);
    req_valid = 1'b0;
  endtask

  task automatic cfg(input int idx, input int b, input int l, input bit priv);
    cfg_we    = 1'b1;
    cfg_priv  = priv;
    cfg_idx   = SEG_W'(idx);
    cfg_base  = PA_W'(b);
    cfg_limit = LIM_W'(l);
    tick();
    cfg_we    = 1'b0;
    cfg_priv  = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL %s: watchdog cycles actual 100000 expected fewer", cur);
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R1: outputs idle in and after reset; unconfigured entries fault
    cur = "R1";
    repeat (3) tick();
    rst = 1'b0;
    tick();
    for (int s = 0; s < NUM_SEG; s++) send(s, 0);
    tick();

    // R2: unprivileged write ignored, privileged write applied
    cur = "R2";
    cfg(1, 9300, 400, 1'b0);
    send(1, 123);
    cfg(1, 9300, 400, 1'b1);
    tick();

    // R3: legal translations including the 9300+123 case
    cur = "R3";
    send(1, 123);
    send(1, 0);
    send(1, 399);

    // R4: offset at and above the limit
    cur = "R4";
    send(1, 400);
    send(1, 4095);
    cfg(0, 20, 0, 1'b1);
    send(0, 0);

    // R5: unimplemented segment numbers
    cur = "R5";
    send(4, 0);
    send(6, 1);
    send(7, 5);

    // R6: sum exactly at the top of the space and one past it
    cur = "R6";
    cfg(2, 65000, 4000, 1'b1);
    send(2, 535);
    send(2, 536);

    // R7: back-to-back stream, one response per accepted request
    cur = "R7";
    for (int k = 0; k < 8; k++) send(k % 3 + 1, k * 50);
    tick();

    // R8: back-pressure holds the response and blocks new requests
    cur = "R8";
    rsp_ready = 1'b0;
    send(1, 10);
    req_valid = 1'b1;
    req_seg   = SEG_W'(2);
    req_off   = OFF_W'(7);
    repeat (4) tick();
    rsp_ready = 1'b1;
    tick();
    req_valid = 1'b0;
    tick();
    tick();

    // R9: write and request to the same entry in one cycle
    cur = "R9";
    cfg_we    = 1'b1;
    cfg_priv  = 1'b1;
    cfg_idx   = SEG_W'(3);
    cfg_base  = PA_W'(500);
    cfg_limit = LIM_W'(50);
    req_valid = 1'b1;
    req_seg   = SEG_W'(3);
    req_off   = OFF_W'(10);
    tick();
    cfg_we    = 1'b0;
    cfg_priv  = 1'b0;
    req_valid = 1'b0;
    tick();
    send(3, 10);
    tick();

    // R7 and R8 mixed: random traffic, stalls and writes
    cur = "R7";
    for (int k = 0; k < 400; k++) begin
      req_valid = 1'($urandom_range(0, 3) != 0);
      rsp_ready = 1'($urandom_range(0, 3) != 0);
      req_seg   = SEG_W'($urandom_range(0, 7));
      req_off   = OFF_W'($urandom_range(0, 600));
      cfg_we    = 1'($urandom_range(0, 9) == 0);
      cfg_priv  = 1'($urandom_range(0, 1));
      cfg_idx   = SEG_W'($urandom_range(0, 7));
      cfg_base  = PA_W'($urandom_range(0, 65535));
      cfg_limit = LIM_W'($urandom_range(0, 700));
      tick();
    end
    req_valid = 1'b0;
    cfg_we    = 1'b0;
    rsp_ready = 1'b1;
    tick();
    tick();
    finish_run();
  end
endmodule